// File: doc/BRIEF.md
# Ternary Search Pattern Aligner

This block widens a narrow ternary search field into the full-width pattern word of a ternary data CAM. A field of up to 16 ternary digits arrives on a 32-bit bus. It is placed at a chosen digit position inside a 64-digit (128-bit) CAM pattern. Every digit outside the placed field is set to don't-care, so a match compares only the selected slice of each stored word.

Three 32-bit buses can supply the field: the local pattern bus, the neighbouring chip's forwarded bus, and a shared routing bus. A 2-bit selector picks one of them. The local bus is also registered and driven back out, so the neighbouring aligner and the routing bus can take it.

The CAM pattern, the overflow flag and the forwarded bus are all registered, with one cycle of latency. A field that would run past digit 63 is cut off there. The cycle in which that happens is marked by the overflow flag.

Top module: `tpa_aligner`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, `cam_pat`, `ovf` and `fwd_pat` are all zero.
- R2: Each output at a rising clock edge reflects the inputs sampled at the previous rising edge: exactly one cycle of latency.
- R3: Digit k of the selected field sits at bits [2k+1:2k] of the source bus. Digit d of the CAM pattern sits at bits [2d+1:2d] of `cam_pat`. Field digit k is written to pattern digit `dig_offset`+k for every k below the effective length.
- R4: Every pattern digit not written by R3 holds the don't-care code 2'b00.
- R5: The effective length equals `fld_len` clamped to 16. A value of 17 to 31 acts as 16, and a length of 0 places no digits at all, leaving the whole pattern don't-care.
- R6: When `dig_offset` plus the effective length exceeds 64, field digits that would land beyond digit 63 are dropped, and `ovf` is 1 for that result cycle only. Otherwise `ovf` is 0. An exact fit ending at digit 63 is not an overflow.
- R7: `src_sel` chooses the field source: 2'b00 the local bus, 2'b01 the neighbour bus, 2'b10 the routing bus, and 2'b11 the local bus.
- R8: `fwd_pat` carries the value that `local_pat` had one cycle earlier, whatever the selector, offset and length.
- R9: Digit codes pass through unchanged, including the unused code 2'b11. The codes are 2'b01 for '0', 2'b10 for '1' and 2'b00 for don't-care.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Field source selector |
| local_pat | input | 32 | Local pattern bus, 16 ternary digits |
| nbr_pat | input | 32 | Bus forwarded from the neighbouring chip |
| route_pat | input | 32 | Shared routing bus |
| dig_offset | input | 6 | Pattern digit where field digit 0 lands |
| fld_len | input | 5 | Field length in digits (clamped to 16) |
| cam_pat | output | 128 | Registered 64-digit ternary CAM pattern |
| ovf | output | 1 | Registered truncation flag |
| fwd_pat | output | 32 | Registered copy of the local bus for neighbour and routing bus |

## Verification
The block's only state is the output register, so any fault in placement, masking or source choice shows up in `cam_pat` on the very edge after the inputs are applied. A wrong offset decode shifts or smears non-zero digits into don't-care positions. A wrong length clamp shows either too many non-zero digits or none. A faulty overflow test flips `ovf` in the same cycle, which is most visible at the offsets 48 and 49 with a length of 16. A stale or mis-wired forward register shows as `fwd_pat` lagging or leading `local_pat` by the wrong number of cycles.

// File: rtl/tpa_pkg.sv
package tpa_pkg;

    // field source codes
    typedef enum logic [1:0] {
        SRC_LOCAL = 2'b00,
        SRC_NBR   = 2'b01,
        SRC_ROUTE = 2'b10,
        SRC_ALT   = 2'b11
    } src_e;

    // ternary digit codes
    localparam logic [1:0] DIG_ANY  = 2'b00;
    localparam logic [1:0] DIG_ZERO = 2'b01;
    localparam logic [1:0] DIG_ONE  = 2'b10;

endpackage

// File: rtl/tpa_src_mux.sv
module tpa_src_mux
    import tpa_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic [1:0]       sel,
    input  logic [BUS_W-1:0] local_bus,
    input  logic [BUS_W-1:0] nbr_bus,
    input  logic [BUS_W-1:0] route_bus,
    output logic [BUS_W-1:0] field
);

    // R7: 2'b11 falls back to the local bus
    always_comb begin
        unique case (src_e'(sel))
            SRC_NBR:   field = nbr_bus;
            SRC_ROUTE: field = route_bus;
            default:   field = local_bus;
        endcase
    end

endmodule

// File: rtl/tpa_digit_slot.sv
module tpa_digit_slot #(
    parameter int SLOT         = 0,
    parameter int FIELD_DIGITS = 16,
    parameter int WORD_DIGITS  = 64,
    parameter int DIGIT_W      = 2
) (
    input  logic [FIELD_DIGITS*DIGIT_W-1:0]     field,
    input  logic [$clog2(WORD_DIGITS)-1:0]      offset,
    input  logic [$clog2(FIELD_DIGITS):0]       len,
    output logic [DIGIT_W-1:0]                  digit
);

    localparam int OFS_W = $clog2(WORD_DIGITS);
    localparam int LEN_W = $clog2(FIELD_DIGITS) + 1;
    localparam int IDX_W = $clog2(FIELD_DIGITS);
    localparam int CMP_W = ((OFS_W > LEN_W) ? OFS_W : LEN_W) + 1;
    localparam logic [OFS_W-1:0] SLOT_V = OFS_W'(SLOT);

    logic [OFS_W-1:0] rel_d;
    logic             hit_d;
    logic [IDX_W-1:0] idx_d;

    // which field digit, if any, belongs in this pattern slot
    always_comb begin
        rel_d = SLOT_V - offset;
        hit_d = (offset <= SLOT_V) && (CMP_W'(rel_d) < CMP_W'(len));
        idx_d = rel_d[IDX_W-1:0];
        digit = hit_d ? field[idx_d*DIGIT_W +: DIGIT_W] : '0;
    end

endmodule

// File: rtl/tpa_aligner.sv
module tpa_aligner #(
    parameter int FIELD_DIGITS = 16,
    parameter int WORD_DIGITS  = 64,
    parameter int DIGIT_W      = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [1:0]                          src_sel,
    input  logic [FIELD_DIGITS*DIGIT_W-1:0]     local_pat,
    input  logic [FIELD_DIGITS*DIGIT_W-1:0]     nbr_pat,
    input  logic [FIELD_DIGITS*DIGIT_W-1:0]     route_pat,
    input  logic [$clog2(WORD_DIGITS)-1:0]      dig_offset,
    input  logic [$clog2(FIELD_DIGITS):0]       fld_len,
    output logic [WORD_DIGITS*DIGIT_W-1:0]      cam_pat,
    output logic                                ovf,
    output logic [FIELD_DIGITS*DIGIT_W-1:0]     fwd_pat
);

    localparam int BUS_W = FIELD_DIGITS * DIGIT_W;
    localparam int PAT_W = WORD_DIGITS * DIGIT_W;
    localparam int LEN_W = $clog2(FIELD_DIGITS) + 1;
    localparam int SUM_W = $clog2(WORD_DIGITS) + 2;

    typedef struct packed {
        logic [PAT_W-1:0] pat;
        logic             ovf;
        logic [BUS_W-1:0] fwd;
    } state_t;

    state_t           state_d, state_q;
    logic [BUS_W-1:0] sel_field;
    logic [LEN_W-1:0] len_eff;
    logic [PAT_W-1:0] placed;

    tpa_src_mux #(.BUS_W(BUS_W)) u_mux (
        .sel       (src_sel),
        .local_bus (local_pat),
        .nbr_bus   (nbr_pat),
        .route_bus (route_pat),
        .field     (sel_field)
    );

    // R5: clamp the length to the field width
    always_comb begin
        len_eff = (fld_len > LEN_W'(FIELD_DIGITS)) ? LEN_W'(FIELD_DIGITS) : fld_len;
    end

    // R3/R4: one placement slot per pattern digit
    for (genvar s = 0; s < WORD_DIGITS; s++) begin : g_slot
        tpa_digit_slot #(
            .SLOT         (s),
            .FIELD_DIGITS (FIELD_DIGITS),
            .WORD_DIGITS  (WORD_DIGITS),
            .DIGIT_W      (DIGIT_W)
        ) u_slot (
            .field  (sel_field),
            .offset (dig_offset),
            .len    (len_eff),
            .digit  (placed[s*DIGIT_W +: DIGIT_W])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.pat = placed;
        state_d.ovf = (SUM_W'(dig_offset) + SUM_W'(len_eff)) > SUM_W'(WORD_DIGITS);
        state_d.fwd = local_pat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign cam_pat = state_q.pat;
    assign ovf     = state_q.ovf;
    assign fwd_pat = state_q.fwd;

    // ---------------- assertions ----------------
    logic [WORD_DIGITS-1:0] nz_q;
    for (genvar a = 0; a < WORD_DIGITS; a++) begin : g_nz
        assign nz_q[a] = |state_q.pat[a*DIGIT_W +: DIGIT_W];
    end

    // R1
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (cam_pat == '0 && !ovf && fwd_pat == '0));

    // R8
    assert_fwd_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> fwd_pat == $past(local_pat));

    // R6
    assert_overflow_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ovf == (32'($past(dig_offset)) > (WORD_DIGITS - 32'($past(len_eff)))));

    // R4: never more non-don't-care digits than the field can hold
    assert_digit_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(nz_q) <= FIELD_DIGITS);

    // R3: the first field digit lands at the offset
    assert_first_digit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(len_eff) != '0) |->
        DIGIT_W'(cam_pat >> (32'($past(dig_offset)) * DIGIT_W)) == $past(sel_field[DIGIT_W-1:0]));

    // R5: zero length leaves the whole pattern don't-care
    assert_zero_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fld_len) == '0) |-> (cam_pat == '0 && !ovf));

endmodule

// File: tb/sim_tpa_aligner.sv
module sim_tpa_aligner;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   src_sel = '0;
    logic [31:0]  local_pat = '0, nbr_pat = '0, route_pat = '0;
    logic [5:0]   dig_offset = '0;
    logic [4:0]   fld_len = '0;
    logic [127:0] cam_pat;
    logic         ovf;
    logic [31:0]  fwd_pat;

    int checks = 0;
    int failures = 0;

    logic [127:0] exp_pat;
    logic         exp_ovf;
    logic [31:0]  exp_fwd;
    bit           have_exp = 0;

    always #4 clk = ~clk;

    tpa_aligner u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
        .local_pat(local_pat), .nbr_pat(nbr_pat), .route_pat(route_pat),
        .dig_offset(dig_offset), .fld_len(fld_len),
        .cam_pat(cam_pat), .ovf(ovf), .fwd_pat(fwd_pat)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(cam_pat == exp_pat, {tag, " R2 pattern"}, cam_pat, exp_pat);
        chk(ovf == exp_ovf, {tag, " R6 flag"}, 128'(ovf), 128'(exp_ovf));
        chk(fwd_pat == exp_fwd, {tag, " R8 forward"}, 128'(fwd_pat), 128'(exp_fwd));
    endtask

    // behavioural reference: drive at a falling edge, result due after next rising edge
    task automatic step(input logic [1:0] s, input logic [31:0] l, input logic [31:0] n,
                        input logic [31:0] r, input int ofs, input int len, input string tag);
        logic [31:0] f;
        int le;
        @(negedge clk);
        if (have_exp) compare(tag);
        src_sel = s; local_pat = l; nbr_pat = n; route_pat = r;
        dig_offset = 6'(ofs); fld_len = 5'(len);
        f = (s == 2'b01) ? n : (s == 2'b10) ? r : l;   // R7
        le = (len > 16) ? 16 : len;                    // R5
        exp_pat = '0;                                  // R4
        for (int j = 0; j < 64; j++) begin
            int k = j - ofs;
            if (k >= 0 && k < le) exp_pat[2*j +: 2] = f[2*k +: 2];   // R3, R9
        end
        exp_ovf = (ofs + le) > 64;                     // R6
        exp_fwd = l;                                   // R8
        have_exp = 1;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset holds outputs at zero even with busy inputs
        local_pat = 32'hFFFF_FFFF; fld_len = 5'd16; dig_offset = 6'd60;
        repeat (3) @(negedge clk);
        chk(cam_pat == '0, "R1 pattern in reset", cam_pat, '0);
        chk(ovf == 1'b0, "R1 flag in reset", 128'(ovf), '0);
        chk(fwd_pat == '0, "R1 forward in reset", 128'(fwd_pat), '0);
        rst_n = 1'b1;

        step(2'b00, 32'hE4E4_E4E4, 0, 0, 0, 16, "R3 R9 full field at 0");
        step(2'b00, 32'h0000_0196, 0, 0, 5, 3, "R3 R4 short field");
        step(2'b00, 32'h5A5A_A5A5, 0, 0, 48, 16, "R6 exact fit");
        step(2'b00, 32'h6969_9696, 0, 0, 49, 16, "R6 overflow by one");
        step(2'b00, 32'h1234_5678, 0, 0, 20, 4, "R6 flag drops");
        step(2'b00, 32'hFFFF_FFFF, 0, 0, 63, 5, "R6 last digit");
        step(2'b00, 32'hAAAA_AAAA, 0, 0, 10, 0, "R5 zero length");
        step(2'b00, 32'h9999_9999, 0, 0, 10, 31, "R5 clamp");
        step(2'b01, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 7, 9, "R7 neighbour");
        step(2'b10, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 30, 12, "R7 routing");
        step(2'b11, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 33, 16, "R7 alt local");
        for (int i = 0; i < 40; i++)
            step(2'($urandom), $urandom, $urandom, $urandom, int'($urandom % 64), int'($urandom % 32), "R3 R4 R7 mixed");
        step(2'b00, 0, 0, 0, 0, 0, "R2 flush");
        step(2'b00, 0, 0, 0, 0, 0, "R2 idle");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule